// File: doc/BRIEF.md
# Multi-Channel Edge-Selectable Interrupt Status Unit

This block gathers interrupt causes for a 22-channel line interface. Each channel owns an 8-bit sticky status word. Five bits of the word watch live condition levels:

- driver over-current
- transmit clock missing
- transmit loss of signal
- system-side loss of signal
- line-side loss of signal

For each of these bits, software picks the edge that latches it: rising-only or either transition. The other three bits latch on single-cycle event pulses. These come from amplitude overflow and from overflow or underflow of the transmit and receive jitter FIFOs.

Software reaches three byte registers per channel over a plain synchronous register bus: status, interrupt enable mask and edge select. Writing a 1 to a status bit clears that bit. A single active-high interrupt line is raised whenever any enabled status bit is set in any channel. The condition and event sources are produced elsewhere.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, every status register reads 0x00, every enable mask reads 0xFF, every edge-select register reads 0x00, and `irq_o` is low.
- R2: The status register of channel n (n from 1 to 21) is at address 0x020 + 0x40*(n-1), and channel 0's is at 0x7E0. The enable mask is at status address + 1 and the edge-select register at status address + 2. Reads of any other address return 0x00, and writes to them change nothing.
- R3: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Mask and edge-select writes store `bus_wdata` as given.
- R4: With edge-select bit k at 0 (k = 4, 3, 2), status bit k is set only by a 0-to-1 change of live condition k; a 1-to-0 change does not set it.
- R5: With edge-select bit k at 1, both a 0-to-1 and a 1-to-0 change of live condition k set status bit k.
- R6: Status bits 1 and 0 both take their edge mode from edge-select bit 1. Edge-select bit 0 has no effect on capture.
- R7: A one-cycle pulse on event input j (j = 0, 1, 2) sets status bit 5+j: bit 5 is receive jitter FIFO, bit 6 is transmit jitter FIFO, bit 7 is amplitude overflow.
- R8: When a set cause and a write-1 clear hit the same status bit in the same cycle, the bit ends up at 1.
- R9: Edges are found by comparing each live condition with its value one clock earlier. While reset is held, the stored value follows the input, so a condition already high when reset ends produces no event.
- R10: `irq_o` is high exactly when some channel has a status bit at 1 whose enable mask bit is also 1.
- R11: A set status bit stays set while its cause returns to idle, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 11 | Register address, shared by reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cond_lvl | input | 110 | Live conditions, 5 per channel, channel c at [5c+4:5c], bit order matches status bits 4..0 |
| cond_evt | input | 66 | Event pulses, 3 per channel, channel c at [3c+2:3c], bit j sets status bit 5+j |
| irq_o | output | 1 | Active-high aggregated interrupt |

## Verification
A status bit can be set by a hardware cause and cleared by a write-1 in the same cycle. The bench provokes this on purpose: it pulses an event input while writing that same bit with 1, and it expects the bit to read back as 1 (R8). The random phase overlaps condition toggles, event pulses and status writes on random channels often enough that such same-cycle collisions happen regularly. A bench model resolves each collision with set-over-clear, and every readback and the interrupt line are compared against that model.

// File: rtl/irq_cap_pkg.sv
// Shared definitions for the interrupt status unit.
// Assumes channel base addresses are aligned to 4 bytes.
package irq_cap_pkg;

    // Register offsets inside one channel's window.
    typedef enum logic [1:0] {
        OFF_STAT = 2'd0,
        OFF_MASK = 2'd1,
        OFF_ESEL = 2'd2
    } reg_off_e;

    // Base address of a channel: index 0 is the extra channel at its own address.
    function automatic int unsigned chan_base(input int unsigned idx,
                                              input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned xtra);
        return (idx == 0) ? xtra : base + stride * (idx - 1);
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
// Address decoder: one hit line per channel, plus the register offset.
// Assumes every channel base is 4-byte aligned and that channel windows do not overlap.
// Offset 3 of each window is left unmapped.
module irq_addr_dec
    import irq_cap_pkg::*;
#(
    parameter int unsigned NUM_CH = 22,
    parameter int unsigned AW     = 11,
    parameter int unsigned BASE   = 'h020,
    parameter int unsigned STRIDE = 'h040,
    parameter int unsigned XTRA   = 'h7E0
) (
    input  logic [AW-1:0]     addr,
    output logic [NUM_CH-1:0] hit,
    output logic [1:0]        off
);

    // Per-channel window compare.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam int unsigned  CB  = chan_base(c, BASE, STRIDE, XTRA);
        localparam logic [AW-1:0] CBV = AW'(CB);
        assign hit[c] = (addr[AW-1:2] == CBV[AW-1:2]) && (addr[1:0] != 2'd3);
    end

    // Register offset within the window.
    assign off = addr[1:0];

endmodule

// File: rtl/irq_edge_det.sv
// Edge detector: per bit, either a rising edge or any edge, as chosen by any_i.
// The previous-value register loads the live input on every clock, reset
// included, so a level that is high when reset ends produces no edge.
module irq_edge_det #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] any_i,
    output logic [W-1:0] edge_o
);

    logic [W-1:0] prev_q;

    // Track the condition one clock late.
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    // Rising edge always counts; falling edge counts only in any-edge mode.
    always_comb begin
        edge_o = (lvl_i & ~prev_q) | (any_i & prev_q & ~lvl_i);
    end

endmodule

// File: rtl/irq_chan_regs.sv
// One channel's status, enable mask and edge-select registers.
// Status bits [LVL_W-1:0] latch on edges of live conditions; bits above latch on event pulses.
// Status bit 0 borrows edge-select bit 1. Assumes LVL_W is at least 5.
module irq_chan_regs #(
    parameter int unsigned LVL_W = 5,
    parameter int unsigned EVT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stat,
    input  logic                   wr_mask,
    input  logic                   wr_esel,
    input  logic [LVL_W+EVT_W-1:0] wdata,
    input  logic [LVL_W-1:0]       lvl_i,
    input  logic [EVT_W-1:0]       evt_i,
    output logic [LVL_W+EVT_W-1:0] stat_o,
    output logic [LVL_W+EVT_W-1:0] mask_o,
    output logic [LVL_W+EVT_W-1:0] esel_o,
    output logic                   pend_o
);

    localparam int unsigned DW = LVL_W + EVT_W;

    logic [DW-1:0]    stat_q, mask_q, esel_q;
    logic [LVL_W-1:0] esel_eff, edge_v;
    logic [DW-1:0]    set_v, clr_v;

    // Edge mode per level bit; bit 0 shares the control of bit 1.
    for (genvar k = 0; k < LVL_W; k++) begin : g_mode
        if (k == 0) begin : g_shared
            assign esel_eff[k] = esel_q[1];
        end else begin : g_own
            assign esel_eff[k] = esel_q[k];
        end
    end

    irq_edge_det #(.W(LVL_W)) u_edge (
        .clk    (clk),
        .lvl_i  (lvl_i),
        .any_i  (esel_eff),
        .edge_o (edge_v)
    );

    // Set causes and write-1 clear mask.
    always_comb begin
        set_v = {evt_i, edge_v};
        clr_v = wr_stat ? wdata : '0;
    end

    // Sticky status; a set cause overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | set_v;
    end

    // Enable mask, all enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= wdata;
    end

    // Edge-select register, rising-only after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       esel_q <= '0;
        else if (wr_esel) esel_q <= wdata;
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign esel_o = esel_q;
    assign pend_o = |(stat_q & mask_q);

    // R3: bits written 1 are clear next cycle unless a cause set them.
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(wdata) & ~$past(set_v)) == '0));

    // R8: every set cause leaves its bit at 1.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    // R11: with no status write, set bits remain set.
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R4: in rising mode a falling level leaves a clear bit clear.
    assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!esel_q[2] && $fell(lvl_i[2]) && !stat_q[2]) |=> !stat_q[2]);

    // R5: in any-edge mode a falling level sets the bit.
    assert_any_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (esel_q[3] && $fell(lvl_i[3])) |=> stat_q[3]);

    // R6: bit 0 follows edge-select bit 1, whatever edge-select bit 0 holds.
    assert_shared_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!esel_q[1] && $fell(lvl_i[0]) && !stat_q[0]) |=> !stat_q[0]);

    // R7: an event pulse on input 0 sets status bit LVL_W.
    assert_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> stat_q[LVL_W]);

endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit: address decode, one register set per
// channel, read multiplexer and interrupt OR tree.
// Assumes a single-cycle write strobe and a combinational read of bus_addr.
module irq_status_unit
    import irq_cap_pkg::*;
#(
    parameter int unsigned NUM_CH = 22,
    parameter int unsigned AW     = 11,
    parameter int unsigned LVL_W  = 5,
    parameter int unsigned EVT_W  = 3,
    parameter int unsigned BASE   = 'h020,
    parameter int unsigned STRIDE = 'h040,
    parameter int unsigned XTRA   = 'h7E0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [LVL_W+EVT_W-1:0]  bus_wdata,
    output logic [LVL_W+EVT_W-1:0]  bus_rdata,
    input  logic [NUM_CH*LVL_W-1:0] cond_lvl,
    input  logic [NUM_CH*EVT_W-1:0] cond_evt,
    output logic                    irq_o
);

    localparam int unsigned DW = LVL_W + EVT_W;

    logic [NUM_CH-1:0] hit, pend;
    logic [1:0]        off;
    logic [DW-1:0]     stat_a [NUM_CH];
    logic [DW-1:0]     mask_a [NUM_CH];
    logic [DW-1:0]     esel_a [NUM_CH];

    irq_addr_dec #(
        .NUM_CH (NUM_CH), .AW (AW), .BASE (BASE), .STRIDE (STRIDE), .XTRA (XTRA)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .off  (off)
    );

    // One register set per channel, with its own write strobes.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irq_chan_regs #(.LVL_W(LVL_W), .EVT_W(EVT_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stat (bus_wr && hit[c] && (off == OFF_STAT)),
            .wr_mask (bus_wr && hit[c] && (off == OFF_MASK)),
            .wr_esel (bus_wr && hit[c] && (off == OFF_ESEL)),
            .wdata   (bus_wdata),
            .lvl_i   (cond_lvl[c*LVL_W +: LVL_W]),
            .evt_i   (cond_evt[c*EVT_W +: EVT_W]),
            .stat_o  (stat_a[c]),
            .mask_o  (mask_a[c]),
            .esel_o  (esel_a[c]),
            .pend_o  (pend[c])
        );
    end

    // AND-OR read multiplexer; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) begin
                case (off)
                    OFF_STAT: bus_rdata = bus_rdata | stat_a[c];
                    OFF_MASK: bus_rdata = bus_rdata | mask_a[c];
                    OFF_ESEL: bus_rdata = bus_rdata | esel_a[c];
                    default:  bus_rdata = bus_rdata;
                endcase
            end
        end
    end

    // Aggregate interrupt over all channels.
    assign irq_o = |pend;

    // R2: no address selects more than one channel.
    assert_one_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;

    localparam int NCH = 22;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [10:0]      addr = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic [NCH*5-1:0] lvl = '0;
    logic [NCH*3-1:0] evt = '0;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_stat [NCH];
    logic [7:0] m_mask [NCH];
    logic [7:0] m_esel [NCH];
    logic [4:0] m_prev [NCH];

    irq_status_unit uut (
        .clk (clk), .rst_n (rst_n), .bus_wr (wr_en), .bus_addr (addr),
        .bus_wdata (wdata), .bus_rdata (rdata), .cond_lvl (lvl),
        .cond_evt (evt), .irq_o (irq)
    );

    always #10 clk = ~clk;

    function automatic logic [10:0] addr_of(input int ch, input int off);
        logic [10:0] b;
        b = (ch == 0) ? 11'h7E0 : 11'h020 + 11'(ch - 1) * 11'h040;
        return b + 11'(off);
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        for (int c = 0; c < NCH; c++) r = r | (|(m_stat[c] & m_mask[c]));
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Advance the model for the coming edge, then clock the design.
    task automatic tick();
        for (int c = 0; c < NCH; c++) begin
            logic [4:0] l, p, eff, ed;
            logic [7:0] clr;
            l   = lvl[c*5 +: 5];
            p   = m_prev[c];
            eff = {m_esel[c][4:1], m_esel[c][1]};
            ed  = (l & ~p) | (eff & p & ~l);
            clr = (wr_en && addr == addr_of(c, 0)) ? wdata : 8'h00;
            m_stat[c] = (m_stat[c] & ~clr) | {evt[c*3 +: 3], ed};
            if (wr_en && addr == addr_of(c, 1)) m_mask[c] = wdata;
            if (wr_en && addr == addr_of(c, 2)) m_esel[c] = wdata;
            m_prev[c] = l;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        evt   = '0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd(input string tag, input logic [10:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        lvl[3*5 + 2] = 1'b1;            // already high while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            m_stat[c] = 8'h00; m_mask[c] = 8'hFF; m_esel[c] = 8'h00;
            m_prev[c] = lvl[c*5 +: 5];
        end

        // R1: reset values.
        rd("R1 stat ch0", addr_of(0, 0), 8'h00);
        rd("R1 mask ch0", addr_of(0, 1), 8'hFF);
        rd("R1 esel ch7", addr_of(7, 2), 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R9: high-at-reset level gives no event.
        tick();
        rd("R9 ch3 stat", addr_of(3, 0), 8'h00);

        // R4: rising sets, clear, falling ignored.
        lvl[1*5 + 2] = 1'b1; tick();
        rd("R4 rise ch1", addr_of(1, 0), 8'h04);
        wr(addr_of(1, 0), 8'h04);
        lvl[1*5 + 2] = 1'b0; tick();
        rd("R4 fall ignored ch1", addr_of(1, 0), 8'h00);

        // R5: any-edge mode catches the falling edge.
        wr(addr_of(1, 2), 8'h04);
        lvl[1*5 + 2] = 1'b1; tick();
        rd("R5 rise ch1", addr_of(1, 0), 8'h04);
        wr(addr_of(1, 0), 8'h04);
        lvl[1*5 + 2] = 1'b0; tick();
        rd("R5 fall ch1", addr_of(1, 0), 8'h04);

        // R6: bits 1 and 0 use edge-select bit 1; bit 0 of the select is inert.
        wr(addr_of(2, 2), 8'h01);
        lvl[2*5 + 0] = 1'b1; tick();
        wr(addr_of(2, 0), 8'h01);
        lvl[2*5 + 0] = 1'b0; tick();
        rd("R6 esel bit0 inert", addr_of(2, 0), 8'h00);
        wr(addr_of(2, 2), 8'h02);
        lvl[2*5 + 0] = 1'b1; lvl[2*5 + 1] = 1'b1; tick();
        wr(addr_of(2, 0), 8'h03);
        lvl[2*5 + 0] = 1'b0; lvl[2*5 + 1] = 1'b0; tick();
        rd("R6 shared any-edge", addr_of(2, 0), 8'h03);

        // R7: event pulse on input 2 sets bit 7.
        evt[21*3 + 2] = 1'b1; tick();
        rd("R7 evt ch21", addr_of(21, 0), 8'h80);

        // R8: set and clear in the same cycle: set wins.
        evt[21*3 + 2] = 1'b1; wr(addr_of(21, 0), 8'h80);
        rd("R8 set wins", addr_of(21, 0), 8'h80);
        wr(addr_of(21, 0), 8'h80);
        rd("R8 later clear", addr_of(21, 0), 8'h00);

        // R3: write-0 keeps, write-1 clears only its bits.
        evt[4*3 +: 3] = 3'b111; tick();
        wr(addr_of(4, 0), 8'h00);
        rd("R3 write zero", addr_of(4, 0), 8'hE0);
        wr(addr_of(4, 0), 8'h40);
        rd("R3 partial clear", addr_of(4, 0), 8'hA0);

        // R11: ch1 bit 2 remains set long after its cause.
        rd("R11 sticky ch1", addr_of(1, 0), 8'h04);

        // R10: clear everything, then gate one bit by the mask.
        for (int c = 0; c < NCH; c++) wr(addr_of(c, 0), 8'hFF);
        chk("R10 all clear", {7'd0, irq}, 8'h00);
        evt[4*3 + 0] = 1'b1; tick();
        chk("R10 enabled", {7'd0, irq}, 8'h01);
        wr(addr_of(4, 1), 8'hDF);
        chk("R10 masked", {7'd0, irq}, 8'h00);
        rd("R10 masked stat kept", addr_of(4, 0), 8'h20);
        wr(addr_of(4, 1), 8'h20);
        chk("R10 re-enabled", {7'd0, irq}, 8'h01);

        // R2: address map and unmapped space.
        wr(11'h7E1, 8'h55);
        rd("R2 ch0 mask", addr_of(0, 1), 8'h55);
        wr(11'h523, 8'hAA);
        rd("R2 unmapped 0x523", 11'h523, 8'h00);
        wr(11'h003, 8'hAA);
        rd("R2 unmapped 0x003", 11'h003, 8'h00);
        wr(11'h522, 8'h1E);
        rd("R2 ch21 esel", 11'h522, 8'h1E);
        rd("R2 ch20 mask", 11'h4E1, 8'hFF);

        // Random phase checked against the model.
        for (int i = 0; i < 3000; i++) begin
            int ch, off;
            for (int b = 0; b < NCH*5; b++) if ($urandom % 8 == 0) lvl[b] = ~lvl[b];
            for (int b = 0; b < NCH*3; b++) evt[b] = ($urandom % 16 == 0);
            if ($urandom % 3 == 0) begin
                ch = $urandom % NCH; off = $urandom % 4;
                wr_en = 1'b1; addr = addr_of(ch, off); wdata = 8'($urandom);
            end
            tick();
            chk("R10 random irq", {7'd0, irq}, {7'd0, exp_irq()});
            ch = $urandom % NCH; off = $urandom % 3;
            case (off)
                0: rd("R11 random stat", addr_of(ch, 0), m_stat[ch]);
                1: rd("R2 random mask", addr_of(ch, 1), m_mask[ch]);
                default: rd("R2 random esel", addr_of(ch, 2), m_esel[ch]);
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule